// File: doc/BRIEF.md
# Edge Interrupt Cause Aggregator

This block watches a set of up to 32 general-purpose inputs, already brought into the local clock domain, and records edge events on them. For each pin, one enable register arms rising-edge capture and another arms falling-edge capture. The two are independent, so a pin can catch both kinds of edge. Every caught edge sets a sticky cause bit, and the bit stays set until software writes a 1 to the matching position of a dedicated clear register.

A separate event-enable mask decides which cause bits count. The masked causes can be read from a status register, and their OR drives a single level interrupt line that may be shared with other sources. Cause bits latch whether or not the mask bit is set, so turning on a mask bit later reports an event that is already pending. Software reaches everything through a plain 32-bit register port: a write strobe with an address and data, and a read data bus that always shows the addressed register.

Top module: `edge_cause_agg`

## Requirements
- R1: While reset (rst_n low) is applied at a clock edge, the rising-enable, falling-enable, mask and cause registers all clear to 0. After that edge, irq_o is low and every register reads 0.
- R2: A pin whose bit is set in the rising-enable register (offset 0x44) sets its cause bit at the clock edge where the pin is 1 and was 0 at the previous edge.
- R3: A pin whose bit is set in the falling-enable register (offset 0x48) sets its cause bit at the clock edge where the pin is 0 and was 1 at the previous edge.
- R4: With both enables set, a pin catches both edge kinds. With neither enable set, edges on the pin leave its cause bit unchanged. An enable write takes effect for edges from the following clock edge onwards.
- R5: Writing to the clear register (offset 0x98) clears every cause bit whose data bit is 1. Data bits of 0 leave their cause bits as they were.
- R6: If an enabled edge and a clear of the same bit happen at the same clock edge, the cause bit is set after that edge.
- R7: Cause bits latch regardless of the mask. Reading offset 0x98 returns the raw cause bits. Reading offset 0x80 returns the cause bits ANDed with the mask at offset 0x94.
- R8: irq_o is high exactly when at least one cause bit is set whose mask bit is also set. This holds on the cycle after the edge, clear or mask write that changes it.
- R9: Offsets 0x44, 0x48 and 0x94 read back the last written value, limited to the NPINS low bits. Bits above NPINS read 0. Writes to 0x80 and to unused offsets change nothing, and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | NPINS | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Level interrupt, OR of masked causes |

## Verification
A wrong value in the previous-level register of a pin would show up as a phantom or missing cause bit. This appears at the raw cause read on the very next cycle, and on irq_o as well if that pin is masked in. A cause bit that is lost, sticks after a clear, or loses the race against a simultaneous clear would differ from the reference one cycle after the edge or clear. The bench compares the addressed register and irq_o against a behavioural model on every clock. It spends long stretches reading the raw cause and status registers, so that a fault in a single bit is seen within a cycle.

// File: rtl/ecag_pkg.sv
// Package: shared offsets and register-select decoding for the edge
// interrupt cause aggregator. Assumes an 8-bit byte address space.
package ecag_pkg;

    localparam int unsigned ECAG_AW = 8;

    localparam logic [ECAG_AW-1:0] OFS_RISE_EN = 8'h44;
    localparam logic [ECAG_AW-1:0] OFS_FALL_EN = 8'h48;
    localparam logic [ECAG_AW-1:0] OFS_STATUS  = 8'h80;
    localparam logic [ECAG_AW-1:0] OFS_MASK    = 8'h94;
    localparam logic [ECAG_AW-1:0] OFS_CLEAR   = 8'h98;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RISE,
        SEL_FALL,
        SEL_STATUS,
        SEL_MASK,
        SEL_CLEAR
    } reg_sel_e;

    // Map a byte offset onto the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [ECAG_AW-1:0] ofs);
        case (ofs)
            OFS_RISE_EN: return SEL_RISE;
            OFS_FALL_EN: return SEL_FALL;
            OFS_STATUS:  return SEL_STATUS;
            OFS_MASK:    return SEL_MASK;
            OFS_CLEAR:   return SEL_CLEAR;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ecag_edge_detect.sv
// Module: per-pin edge detector. Compares each pin with its level at the
// previous clock edge and reports an event when the edge kind is enabled.
// Assumes pin_i is already synchronous to clk. The previous-level register
// resets to 0; a pin that sits high is not reported as an edge, because the
// enables are still 0 in the first cycle after reset.
module ecag_edge_detect #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] rise_en_i,
    input  logic [NPINS-1:0] fall_en_i,
    output logic [NPINS-1:0] evt_o
);

    logic [NPINS-1:0] prev_q;

    // Hold each pin's level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_i;
    end

    // Build the per-pin event from the enabled edge kinds.
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic went_up;
        logic went_down;
        assign went_up   = pin_i[g] & ~prev_q[g];
        assign went_down = ~pin_i[g] & prev_q[g];
        assign evt_o[g]  = (went_up & rise_en_i[g]) | (went_down & fall_en_i[g]);
    end

endmodule

// File: rtl/ecag_cause_bank.sv
// Module: sticky cause flags. Each bit is set by an event and cleared by a
// write-1 clear pulse. When both arrive together the event wins.
// Assumes clr_i is a single-cycle pulse vector from the register port.
module ecag_cause_bank #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] cause_o
);

    for (genvar g = 0; g < NPINS; g++) begin : g_flag
        logic flag_q;
        // Keep the flag until cleared; a new event overrides the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (evt_i[g])   flag_q <= 1'b1;
            else if (clr_i[g])   flag_q <= 1'b0;
        end
        assign cause_o[g] = flag_q;
    end

endmodule

// File: rtl/ecag_regfile.sv
// Module: register port. Holds the rising, falling and mask registers,
// generates the clear pulse vector and returns the addressed read data.
// Assumes DATA_W >= NPINS; bits above NPINS read 0 and are dropped on write.
module ecag_regfile
    import ecag_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ECAG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NPINS-1:0]   cause_i,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NPINS-1:0]   rise_en_o,
    output logic [NPINS-1:0]   fall_en_o,
    output logic [NPINS-1:0]   mask_o,
    output logic [NPINS-1:0]   clr_o
);

    reg_sel_e         sel;
    logic [NPINS-1:0] wr_bits;
    logic [NPINS-1:0] rd_bits;

    assign sel     = decode_ofs(bus_addr);
    assign wr_bits = bus_wdata[NPINS-1:0];

    // Update the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_o <= '0;
            fall_en_o <= '0;
            mask_o    <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_RISE) rise_en_o <= wr_bits;
            if (sel == SEL_FALL) fall_en_o <= wr_bits;
            if (sel == SEL_MASK) mask_o    <= wr_bits;
        end
    end

    // Turn a write to the clear offset into a one-cycle clear vector.
    always_comb begin
        clr_o = '0;
        if (bus_wr && sel == SEL_CLEAR) clr_o = wr_bits;
    end

    // Select the read data of the addressed register.
    always_comb begin
        case (sel)
            SEL_RISE:   rd_bits = rise_en_o;
            SEL_FALL:   rd_bits = fall_en_o;
            SEL_STATUS: rd_bits = cause_i & mask_o;
            SEL_MASK:   rd_bits = mask_o;
            SEL_CLEAR:  rd_bits = cause_i;
            default:    rd_bits = '0;
        endcase
    end

    // Zero-extend to the bus width.
    always_comb begin
        bus_rdata              = '0;
        bus_rdata[NPINS-1:0]   = rd_bits;
    end

endmodule

// File: rtl/edge_cause_agg.sv
// Module: top of the edge interrupt cause aggregator. Connects the edge
// detector, sticky cause bank and register port, and ORs masked causes into
// one level interrupt. Assumes synchronized pins and a synchronous active-low
// reset.
module edge_cause_agg
    import ecag_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pin_i,
    input  logic               bus_wr,
    input  logic [ECAG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    logic [NPINS-1:0] rise_vec;
    logic [NPINS-1:0] fall_vec;
    logic [NPINS-1:0] mask_vec;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] evt_vec;
    logic [NPINS-1:0] cause_vec;

    ecag_regfile #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cause_i   (cause_vec),
        .bus_rdata (bus_rdata),
        .rise_en_o (rise_vec),
        .fall_en_o (fall_vec),
        .mask_o    (mask_vec),
        .clr_o     (clr_vec)
    );

    ecag_edge_detect #(.NPINS(NPINS)) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .rise_en_i (rise_vec),
        .fall_en_i (fall_vec),
        .evt_o     (evt_vec)
    );

    ecag_cause_bank #(.NPINS(NPINS)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_vec),
        .clr_i   (clr_vec),
        .cause_o (cause_vec)
    );

    // Raise the shared interrupt while any enabled cause is pending.
    assign irq_o = |(cause_vec & mask_vec);

endmodule

// File: rtl/ecag_checker.sv
// Module: assertion checker for edge_cause_agg, attached by bind.
// Assumes it sees the internal vectors of the top through its ports.
module ecag_checker #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic [NPINS-1:0] cause_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] evt_vec,
    input logic [NPINS-1:0] clr_vec
);

    logic past_ok;

    // Mark cycles whose previous sample was taken out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: a reset edge leaves no cause pending and the line low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (cause_q == '0) && !irq_o);

    // R2, R3: a cause bit only appears after an enabled edge event.
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((cause_q & ~$past(cause_q) & ~$past(evt_vec)) == '0));

    // R5: a set cause bit survives unless it was cleared.
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(cause_q) & ~$past(clr_vec) & ~cause_q) == '0));

    // R6: an event together with a clear leaves the bit set.
    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(evt_vec) & $past(clr_vec) & ~cause_q) == '0));

    // R8: the line needs both a pending cause and an open mask.
    p_irq_needs_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cause_q != '0) && (mask_q != '0));

endmodule

bind edge_cause_agg ecag_checker #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_o   (irq_o),
    .cause_q (cause_vec),
    .mask_q  (mask_vec),
    .evt_vec (evt_vec),
    .clr_vec (clr_vec)
);

// File: tb/tb_edge_cause_agg.sv
module tb_edge_cause_agg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = 32'h0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    logic [31:0] m_prev = 0, m_rise = 0, m_fall = 0, m_mask = 0, m_cause = 0;

    edge_cause_agg dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: advance on every rising edge from the driven inputs.
    always @(posedge clk) begin
        logic [31:0] evt, clr;
        if (!rst_n) begin
            m_prev = 0; m_rise = 0; m_fall = 0; m_mask = 0; m_cause = 0;
        end else begin
            evt = (pin_i & ~m_prev & m_rise) | (~pin_i & m_prev & m_fall);
            clr = (bus_wr && bus_addr == 8'h98) ? bus_wdata : 32'h0;
            m_cause = (m_cause & ~clr) | evt;
            if (bus_wr && bus_addr == 8'h44) m_rise = bus_wdata;
            if (bus_wr && bus_addr == 8'h48) m_fall = bus_wdata;
            if (bus_wr && bus_addr == 8'h94) m_mask = bus_wdata;
            m_prev = pin_i;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h44:   return m_rise;
            8'h48:   return m_fall;
            8'h80:   return m_cause & m_mask;
            8'h94:   return m_mask;
            8'h98:   return m_cause;
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] exp_rd;
        logic        exp_irq;
        exp_rd  = model_read(bus_addr);
        exp_irq = |(m_cause & m_mask);
        checks++;
        if (bus_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s: rdata@%h actual %h expected %h", cur_req, bus_addr, bus_rdata, exp_rd);
        end
        checks++;
        if (irq_o !== exp_irq) begin
            errors++;
            $display("FAIL %s: irq_o actual %b expected %b", cur_req, irq_o, exp_irq);
        end
    endtask

    // One cycle: check the state left by the last edge, then drive new inputs.
    task automatic cyc(input logic [31:0] p, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input string req);
        @(negedge clk);
        compare();
        pin_i = p; bus_wr = w; bus_addr = a; bus_wdata = d; cur_req = req;
    endtask

    task automatic rd(input logic [31:0] p, input logic [7:0] a, input string req);
        cyc(p, 1'b0, a, 32'h0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        // R1: reset with busy pins, then read every register.
        pin_i = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(32'hA5A5_0F0F, 8'h44, "R1");
        rd(32'hA5A5_0F0F, 8'h48, "R1");
        rd(32'hA5A5_0F0F, 8'h94, "R1");
        rd(32'hA5A5_0F0F, 8'h98, "R1");
        rd(32'h0, 8'h80, "R1");

        // R9: readback, ignored writes, unused offsets.
        cyc(32'h0, 1'b1, 8'h44, 32'hFFFF_0000, "R9");
        cyc(32'h0, 1'b1, 8'h48, 32'h1234_5678, "R9");
        cyc(32'h0, 1'b1, 8'h94, 32'h8000_0001, "R9");
        cyc(32'h0, 1'b1, 8'h80, 32'hFFFF_FFFF, "R9");
        cyc(32'h0, 1'b1, 8'h10, 32'hFFFF_FFFF, "R9");
        rd(32'h0, 8'h44, "R9");
        rd(32'h0, 8'h48, "R9");
        rd(32'h0, 8'h94, "R9");
        rd(32'h0, 8'h10, "R9");
        rd(32'h0, 8'h80, "R9");

        // R2 with mask closed: causes latch but stay hidden (R7).
        cyc(32'h0, 1'b1, 8'h48, 32'h0, "R2");
        cyc(32'h0, 1'b1, 8'h94, 32'h0, "R2");
        cyc(32'h0, 1'b1, 8'h44, 32'h0000_00FF, "R2");
        rd(32'h0000_0F0F, 8'h98, "R2");
        rd(32'h0000_0F0F, 8'h98, "R2");
        rd(32'h0000_0000, 8'h80, "R7");
        cyc(32'h0, 1'b1, 8'h94, 32'h0000_000C, "R7");
        rd(32'h0, 8'h80, "R7");
        rd(32'h0, 8'h98, "R8");

        // R5: partial clear, zeros leave bits alone.
        cyc(32'h0, 1'b1, 8'h98, 32'h0000_0004, "R5");
        rd(32'h0, 8'h98, "R5");
        cyc(32'h0, 1'b1, 8'h98, 32'h0000_0000, "R5");
        rd(32'h0, 8'h80, "R5");
        cyc(32'h0, 1'b1, 8'h98, 32'hFFFF_FFFF, "R5");
        rd(32'h0, 8'h98, "R5");

        // R3: falling edges only.
        cyc(32'h0, 1'b1, 8'h44, 32'h0, "R3");
        cyc(32'h00F0_00F0, 1'b1, 8'h48, 32'h00FF_0000, "R3");
        rd(32'h00F0_00F0, 8'h98, "R3");
        rd(32'h0000_0000, 8'h98, "R3");
        cyc(32'h0, 1'b1, 8'h94, 32'hFFFF_FFFF, "R3");
        rd(32'h0, 8'h80, "R3");
        cyc(32'h0, 1'b1, 8'h98, 32'hFFFF_FFFF, "R3");

        // R4: both edges on one pin, neither on another.
        cyc(32'h0, 1'b1, 8'h44, 32'h0000_0100, "R4");
        cyc(32'h0, 1'b1, 8'h48, 32'h0000_0100, "R4");
        rd(32'h0000_0300, 8'h98, "R4");
        cyc(32'h0000_0300, 1'b1, 8'h98, 32'h0000_0100, "R4");
        rd(32'h0000_0000, 8'h98, "R4");
        rd(32'h0000_0000, 8'h98, "R4");

        // R6: edge and clear of the same bit on one clock edge.
        cyc(32'h0, 1'b1, 8'h98, 32'hFFFF_FFFF, "R6");
        cyc(32'h0000_0100, 1'b1, 8'h98, 32'h0000_0100, "R6");
        rd(32'h0000_0100, 8'h98, "R6");
        rd(32'h0000_0100, 8'h80, "R6");

        // R8: pseudo-random pins, clears and mask updates.
        cyc(32'h0, 1'b1, 8'h44, 32'hF0F0_3C3C, "R8");
        cyc(32'h0, 1'b1, 8'h48, 32'h0FF0_C33C, "R8");
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = (i % 3 == 0) ? 8'h80 : 8'h98;
            if (i % 7 == 3)       cyc(lfsr, 1'b1, 8'h98, {lfsr[15:0], lfsr[31:16]}, "R8");
            else if (i % 13 == 5) cyc(lfsr, 1'b1, 8'h94, lfsr ^ 32'h5A5A_5A5A, "R8");
            else                  rd(lfsr, a, "R8");
        end
        rd(32'h0, 8'h80, "R8");
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule